// File: doc/BRIEF.md
# Shader Operand Fetch with Swizzle

This block builds the three source operands of one vertex-program instruction. It takes the three instruction words that hold the source fields and reads the register files through synchronous read ports. Each source reads from one of three places: a temporary register, an input attribute register or a constant slot. After the read, each source gets its own component shuffle and, optionally, a sign flip. The three operands appear one cycle after the instruction, marked by a valid strobe. Arithmetic and writeback take place downstream.

The three sources share one constant index and one input index. Each source has its own selector, register number, negate flag and four shuffle codes. The constant address can be offset by the signed address register. Temporary number 12 does not read the temporary file: it returns the current position output vector, which is sampled together with the instruction.

An operand is 128 bits wide. Component X occupies bits 31:0, Y bits 63:32, Z bits 95:64 and W bits 127:96. The same layout applies to every register-file read port and to the position vector.

Top module: `opf_operand_fetch`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The three operands shown in that cycle belong to that instruction.
- R2: The fields are decoded at fixed positions.
  - Source A: negate at word1[8], shuffle at word1[7:0], register at word2[31:28], selector at word2[27:26].
  - Source B: negate at word2[25], shuffle at word2[24:17], register at word2[16:13], selector at word2[12:11].
  - Source C: negate at word2[10], shuffle at word2[9:2], selector at word3[29:28]. Its register number is {word2[1:0], word3[31:30]}.
  - All other word bits are ignored.
- R3: Selector 1 reads a temporary, selector 2 reads the input register and selector 3 reads the constant slot. Selector 0 gives an all-zero operand, and its negate flag has no effect.
- R4: Each 8-bit shuffle field holds four 2-bit codes: bits 7:6 fill result X, 5:4 fill Y, 3:2 fill Z and 1:0 fill W. Code 0 picks source component X, 1 picks Y, 2 picks Z and 3 picks W.
- R5: When a source's negate flag is set, bit 31 of every result component is inverted after the shuffle. This applies to selectors 1 to 3.
- R6: Temporary number 12 returns the position vector sampled in the cycle of `in_valid`. Temporary numbers 13 to 15 read as zero before negation.
- R7: All sources share the input index at word1[12:9] and the constant index at word1[20:13]. When word3[1] is set, the effective constant address is the index plus the signed `addr_reg_x`. Otherwise it is the index alone.
- R8: An effective constant address below 0 or above 191 makes the constant operand read as zero before negation. It also sets `const_range_err`, which becomes visible together with `out_valid`.
- R9: After reset, `out_valid` and `const_range_err` are low. Once set, `const_range_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction words are present this cycle |
| instr_w1 | input | 32 | Instruction word 1 |
| instr_w2 | input | 32 | Instruction word 2 |
| instr_w3 | input | 32 | Instruction word 3 |
| addr_reg_x | input | 10 | Signed address register, used for relative constant access |
| pos_vec | input | 128 | Current position output vector |
| tmp_rd_addr | output | 12 | Temporary read addresses, 4 bits per source, source A lowest |
| tmp_rd_data | input | 384 | Temporary read data, 128 bits per source, one cycle after the address |
| in_rd_addr | output | 4 | Input register read address |
| in_rd_data | input | 128 | Input register read data, one cycle after the address |
| const_rd_addr | output | 8 | Constant read address |
| const_rd_data | input | 128 | Constant read data, one cycle after the address |
| out_valid | output | 1 | The operands are valid |
| opnd_a | output | 128 | Source A operand |
| opnd_b | output | 128 | Source B operand |
| opnd_c | output | 128 | Source C operand |
| const_range_err | output | 1 | Sticky flag: a constant address was out of range |

## Verification
All stored control is captured in the `in_valid` cycle and used in the very next cycle, so a wrong internal state shows up at the operand ports within one cycle of the faulty instruction. A corrupted captured selector, shuffle or negate bit shows at once as wrong component data or a flipped bit 31. A wrong address computation shows as data from the wrong constant slot. A range flag that is missed or cleared by mistake shows on `const_range_err` in the same cycle as `out_valid` or on any later instruction. Boundary addresses 0 and 191, and the first addresses outside them in both directions, are driven on purpose.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int COMP_W = 32;
  localparam int NCOMP  = 4;
  localparam int VEC_W  = COMP_W * NCOMP;
  localparam int NSRC   = 3;
  localparam int REG_W  = 4;
  localparam int CODE_W = 2;
  localparam int SWZ_W  = CODE_W * NCOMP;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_TMP   = 2'd1,
    SEL_IN    = 2'd2,
    SEL_CONST = 2'd3
  } src_sel_e;

  typedef struct packed {
    src_sel_e           sel;
    logic [REG_W-1:0]   rg;
    logic               neg;
    logic [SWZ_W-1:0]   swz;
  } src_fld_t;

  // Result component k takes the source component named by code k
  // (code for X in the top bits); the sign bit flips after the pick.
  function automatic vec_t shuffle_sign(vec_t v, logic [SWZ_W-1:0] swz, logic neg);
    vec_t r;
    logic [CODE_W-1:0] code;
    for (int k = 0; k < NCOMP; k++) begin
      code = swz[SWZ_W-1-CODE_W*k -: CODE_W];
      r[k*COMP_W +: COMP_W] = v[int'(code)*COMP_W +: COMP_W]
                              ^ {neg, {(COMP_W-1){1'b0}}};
    end
    return r;
  endfunction
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
#(
  parameter int CIDX_W      = 8,
  parameter int IIDX_W      = 4,
  parameter int A0_W        = 10,
  parameter int CONST_DEPTH = 192
) (
  input  logic [31:0]       w1,
  input  logic [31:0]       w2,
  input  logic [31:0]       w3,
  input  logic [A0_W-1:0]   a0,
  output src_fld_t          flds [NSRC],
  output logic [IIDX_W-1:0] in_idx,
  output logic [CIDX_W-1:0] const_addr,
  output logic              const_oor
);
  localparam int EFF_W = ((CIDX_W + 1 > A0_W) ? CIDX_W + 1 : A0_W) + 1;
  localparam logic [EFF_W-1:0] DEPTH_E = EFF_W'(CONST_DEPTH);

  logic [CIDX_W-1:0] cidx;
  logic              rel;
  logic [EFF_W-1:0]  a0_ext;
  logic [EFF_W-1:0]  eff;
  logic              unused_bits;

  assign cidx   = w1[13 +: CIDX_W];
  assign in_idx = w1[9 +: IIDX_W];
  assign rel    = w3[1];
  assign unused_bits = ^{w1[31:21], w3[27:2], w3[0]};

  assign flds[0] = '{sel: src_sel_e'(w2[27:26]), rg: w2[31:28],
                     neg: w1[8],  swz: w1[7:0]};
  assign flds[1] = '{sel: src_sel_e'(w2[12:11]), rg: w2[16:13],
                     neg: w2[25], swz: w2[24:17]};
  assign flds[2] = '{sel: src_sel_e'(w3[29:28]), rg: {w2[1:0], w3[31:30]},
                     neg: w2[10], swz: w2[9:2]};

  // Signed sum; a negative result compares as a huge unsigned value,
  // so one comparison covers both ends of the range.
  assign a0_ext     = {{(EFF_W-A0_W){a0[A0_W-1]}}, a0};
  assign eff        = {{(EFF_W-CIDX_W){1'b0}}, cidx} + (rel ? a0_ext : '0);
  assign const_oor  = (eff >= DEPTH_E);
  assign const_addr = const_oor ? '0 : eff[CIDX_W-1:0];
endmodule

// File: rtl/opf_lane.sv
module opf_lane
  import opf_pkg::*;
#(
  parameter int POS_TMP = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap,
  input  src_fld_t fld,
  input  vec_t     tmp_data,
  input  vec_t     in_data,
  input  vec_t     const_data,
  input  vec_t     pos_q,
  input  logic     oor_q,
  input  logic     out_valid,
  output vec_t     opnd
);
  src_fld_t fld_q;
  vec_t     picked;
  logic     tmp_is_pos;
  logic     tmp_is_void;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fld_q <= '0;
    else if (cap) fld_q <= fld;
  end

  assign tmp_is_pos  = (fld_q.rg == REG_W'(POS_TMP));
  assign tmp_is_void = (fld_q.rg >  REG_W'(POS_TMP));

  always_comb begin
    unique case (fld_q.sel)
      SEL_TMP:   picked = tmp_is_pos ? pos_q : (tmp_is_void ? '0 : tmp_data);
      SEL_IN:    picked = in_data;
      SEL_CONST: picked = oor_q ? '0 : const_data;
      default:   picked = '0;
    endcase
  end

  assign opnd = (fld_q.sel == SEL_ZERO) ? '0
              : shuffle_sign(picked, fld_q.swz, fld_q.neg);

  // R3: selector 0 gives zero regardless of negate
  a_r3_zero_select: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fld_q.sel == SEL_ZERO) |-> (opnd == '0));

  // R6: temporaries above the position alias read as zero
  a_r6_void_tmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fld_q.sel == SEL_TMP && tmp_is_void && !fld_q.neg) |-> (opnd == '0));

  // R8: an out-of-range constant reads as zero
  a_r8_oor_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fld_q.sel == SEL_CONST && oor_q && !fld_q.neg) |-> (opnd == '0));
endmodule

// File: rtl/opf_operand_fetch.sv
module opf_operand_fetch
  import opf_pkg::*;
#(
  parameter int CIDX_W      = 8,
  parameter int IIDX_W      = 4,
  parameter int A0_W        = 10,
  parameter int CONST_DEPTH = 192,
  parameter int POS_TMP     = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [31:0]            instr_w1,
  input  logic [31:0]            instr_w2,
  input  logic [31:0]            instr_w3,
  input  logic [A0_W-1:0]        addr_reg_x,
  input  logic [VEC_W-1:0]       pos_vec,
  output logic [NSRC*REG_W-1:0]  tmp_rd_addr,
  input  logic [NSRC*VEC_W-1:0]  tmp_rd_data,
  output logic [IIDX_W-1:0]      in_rd_addr,
  input  logic [VEC_W-1:0]       in_rd_data,
  output logic [CIDX_W-1:0]      const_rd_addr,
  input  logic [VEC_W-1:0]       const_rd_data,
  output logic                   out_valid,
  output logic [VEC_W-1:0]       opnd_a,
  output logic [VEC_W-1:0]       opnd_b,
  output logic [VEC_W-1:0]       opnd_c,
  output logic                   const_range_err
);
  src_fld_t flds [NSRC];
  logic     const_oor;
  logic     valid_q;
  logic     oor_q;
  logic     err_q;
  vec_t     pos_q;
  vec_t     opnd_arr [NSRC];

  opf_decode #(
    .CIDX_W(CIDX_W), .IIDX_W(IIDX_W), .A0_W(A0_W), .CONST_DEPTH(CONST_DEPTH)
  ) u_dec (
    .w1(instr_w1), .w2(instr_w2), .w3(instr_w3), .a0(addr_reg_x),
    .flds(flds), .in_idx(in_rd_addr), .const_addr(const_rd_addr),
    .const_oor(const_oor)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      oor_q   <= 1'b0;
      err_q   <= 1'b0;
      pos_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        oor_q <= const_oor;
        pos_q <= pos_vec;
        err_q <= err_q | const_oor;
      end
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_lane
    assign tmp_rd_addr[s*REG_W +: REG_W] = flds[s].rg;
    opf_lane #(.POS_TMP(POS_TMP)) u_lane (
      .clk(clk), .rst_n(rst_n), .cap(in_valid), .fld(flds[s]),
      .tmp_data(tmp_rd_data[s*VEC_W +: VEC_W]), .in_data(in_rd_data),
      .const_data(const_rd_data), .pos_q(pos_q), .oor_q(oor_q),
      .out_valid(valid_q), .opnd(opnd_arr[s])
    );
  end

  assign out_valid       = valid_q;
  assign opnd_a          = opnd_arr[0];
  assign opnd_b          = opnd_arr[1];
  assign opnd_c          = opnd_arr[2];
  assign const_range_err = err_q;

  // R1: operands valid exactly one cycle after the instruction
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R9: the range flag never clears without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    const_range_err |=> const_range_err);

  // R8: the flag only rises after an accepted instruction
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(const_range_err) |-> ($past(in_valid) && out_valid));
endmodule

// File: tb/tb_opf_operand_fetch.sv
module tb_opf_operand_fetch;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, in_valid;
  logic [31:0]  w1, w2, w3;
  logic [9:0]   a0;
  logic [127:0] pos_vec;
  logic [11:0]  tmp_rd_addr;
  logic [383:0] tmp_rd_data;
  logic [3:0]   in_rd_addr;
  logic [127:0] in_rd_data;
  logic [7:0]   const_rd_addr;
  logic [127:0] const_rd_data;
  logic         out_valid, err;
  logic [127:0] oa, ob, oc;

  int checks = 0;
  int failures = 0;

  opf_operand_fetch dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .instr_w1(w1), .instr_w2(w2), .instr_w3(w3), .addr_reg_x(a0),
    .pos_vec(pos_vec), .tmp_rd_addr(tmp_rd_addr), .tmp_rd_data(tmp_rd_data),
    .in_rd_addr(in_rd_addr), .in_rd_data(in_rd_data),
    .const_rd_addr(const_rd_addr), .const_rd_data(const_rd_data),
    .out_valid(out_valid), .opnd_a(oa), .opnd_b(ob), .opnd_c(oc),
    .const_range_err(err)
  );

  // kind: 1 temporary, 2 input, 3 constant, 4 position
  function automatic logic [31:0] cval(int kind, int idx, int c);
    return (32'(kind) << 28) | (32'(idx) << 8) | 32'(c);
  endfunction
  function automatic logic [127:0] fvec(int kind, int idx);
    return {cval(kind, idx, 3), cval(kind, idx, 2), cval(kind, idx, 1), cval(kind, idx, 0)};
  endfunction

  always_ff @(posedge clk) begin
    for (int s = 0; s < 3; s++)
      tmp_rd_data[s*128 +: 128] <= fvec(1, int'(tmp_rd_addr[s*4 +: 4]));
    in_rd_data    <= fvec(2, int'(in_rd_addr));
    const_rd_data <= fvec(3, int'(const_rd_addr));
  end

  typedef struct packed {
    logic [1:0] m0; logic [3:0] r0; logic n0; logic [7:0] s0;
    logic [1:0] m1; logic [3:0] r1; logic n1; logic [7:0] s1;
    logic [1:0] m2; logic [3:0] r2; logic n2; logic [7:0] s2;
    logic [7:0] ci; logic [3:0] ii; logic rel; logic [9:0] a0;
  } stim_t;

  localparam stim_t VECS [8] = '{
    '{2'd1,4'd3,1'b0,8'h1B, 2'd2,4'd9,1'b0,8'h1B, 2'd3,4'd0,1'b0,8'h1B, 8'd7,4'd5,1'b0,10'd0},
    '{2'd1,4'd11,1'b1,8'hE4, 2'd0,4'd5,1'b1,8'h1B, 2'd3,4'd2,1'b1,8'h00, 8'd191,4'd0,1'b0,10'd0},
    '{2'd1,4'd12,1'b0,8'hFF, 2'd1,4'd13,1'b0,8'h1B, 2'd2,4'd4,1'b1,8'h55, 8'd0,4'd15,1'b0,10'd0},
    '{2'd3,4'd0,1'b0,8'h9C, 2'd3,4'd1,1'b1,8'hE4, 2'd3,4'd2,1'b0,8'h55, 8'd10,4'd1,1'b1,10'd5},
    '{2'd3,4'd0,1'b0,8'h1B, 2'd2,4'd0,1'b0,8'hE4, 2'd1,4'd0,1'b0,8'h1B, 8'd3,4'd2,1'b1,10'h3FD},
    '{2'd3,4'd0,1'b1,8'h1B, 2'd1,4'd12,1'b1,8'h9C, 2'd1,4'd7,1'b0,8'hAA, 8'd190,4'd3,1'b1,10'd1},
    '{2'd3,4'd0,1'b0,8'h1B, 2'd2,4'd0,1'b0,8'h1B, 2'd2,4'd15,1'b0,8'h1B, 8'd0,4'd8,1'b0,10'd50},
    '{2'd0,4'd15,1'b1,8'hE4, 2'd1,4'd15,1'b1,8'h1B, 2'd0,4'd0,1'b0,8'hFF, 8'd100,4'd0,1'b0,10'd0}
  };

  function automatic int eff_addr(stim_t v);
    return int'(v.ci) + (v.rel ? int'($signed(v.a0)) : 0);
  endfunction

  function automatic logic [127:0] model(logic [1:0] m, logic [3:0] r, logic n,
                                         logic [7:0] sw, stim_t v, int pid);
    logic [127:0] res;
    int e;
    e = eff_addr(v);
    for (int k = 0; k < 4; k++) begin
      int code;
      logic [31:0] c;
      code = int'((sw >> (6 - 2*k)) & 8'd3);
      case (m)
        2'd1:    c = (r == 4'd12) ? cval(4, pid, code) : (r > 4'd12) ? 32'h0 : cval(1, int'(r), code);
        2'd2:    c = cval(2, int'(v.ii), code);
        2'd3:    c = (e < 0 || e > 191) ? 32'h0 : cval(3, e, code);
        default: c = 32'h0;
      endcase
      if (m != 2'd0 && n) c[31] = ~c[31];
      res[k*32 +: 32] = c;
    end
    return res;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; operands are checked one cycle later.
  task automatic issue(stim_t v, int pid, logic exp_err, string tag);
    @(negedge clk);
    w1 = {11'h5A5, v.ci, v.ii, v.n0, v.s0};
    w2 = {v.r0, v.m0, v.n1, v.s1, v.r1, v.m1, v.n2, v.s2, v.r2[3:2]};
    w3 = {v.r2[1:0], v.m2, 26'h2AAAAAA, v.rel, 1'b1};
    a0 = v.a0;
    pos_vec = fvec(4, pid);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    pos_vec = fvec(4, 99);
    check({tag, " R1 valid"}, 128'(out_valid), 128'(1));
    check({tag, " R2 R3 R4 R5 R6 R7 srcA"}, oa, model(v.m0, v.r0, v.n0, v.s0, v, pid));
    check({tag, " R2 R3 R4 R5 R6 R7 srcB"}, ob, model(v.m1, v.r1, v.n1, v.s1, v, pid));
    check({tag, " R2 R3 R4 R5 R6 R7 R8 srcC"}, oc, model(v.m2, v.r2, v.n2, v.s2, v, pid));
    check({tag, " R8 R9 range flag"}, 128'(err), 128'(exp_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset valid", 128'(out_valid), 128'(0));
    check("R9 reset flag", 128'(err), 128'(0));
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    stim_t d;
    rst_n = 1'b0; in_valid = 1'b0;
    w1 = '0; w2 = '0; w3 = '0; a0 = '0; pos_vec = '0;
    do_reset();

    for (int i = 0; i < 8; i++) issue(VECS[i], i + 1, 1'b0, $sformatf("vec%0d", i));

    @(negedge clk);
    check("R1 idle no valid", 128'(out_valid), 128'(0));

    // R8: just above the top, relative
    d = VECS[0];
    d.m0 = 2'd3; d.m1 = 2'd3; d.n1 = 1'b1; d.m2 = 2'd3;
    d.ci = 8'd190; d.rel = 1'b1; d.a0 = 10'd2;
    issue(d, 20, 1'b1, "oor_high");
    // R9: flag stays set on a later in-range instruction
    d.a0 = 10'd0;
    issue(d, 21, 1'b1, "after_oor");
    do_reset();
    // R8: below zero
    d.ci = 8'd2; d.a0 = 10'h3FD;
    issue(d, 22, 1'b1, "oor_low");
    do_reset();
    // R8: absolute index beyond the constant space
    d.ci = 8'd200; d.rel = 1'b0;
    issue(d, 23, 1'b1, "oor_abs");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule